// File: doc/BRIEF.md
# Save RAM Byte-Lane Adapter

This block sits between a 16-bit processor bus and a small battery-backed byte store. The store may be wired to both data lanes, to the upper (even-address) lane alone, or to the lower (odd-address) lane alone. The adapter turns each bus access into one or two byte indices. On reads it fills any lane with no memory behind it with 0xFF. On writes it drops any byte aimed at a lane with no memory.

A bus master presents an address, a word/byte select, write data and a read or write strobe. A two-bit lane mode selects the wiring. A two-bit write-control value must hold the unlock code before any write lands. Read data is registered. It appears one cycle after the read strobe and holds until the next read. Decoding of the window that selects this block, and keeping the contents across power loss, are handled elsewhere.

Top module: `sram_lane_adapter`

## Requirements
- R1: After reset `bus_rdata` is 16'h0000.
- R2: Only the low WIN_BITS (default 8) bits of `bus_addr` are used, so addresses that differ only above those bits reach the same storage byte.
- R3: With lane mode 2'b00 (both lanes), a word read returns the byte at masked address a in bits 15:8 and the byte at (a+1) modulo 2^WIN_BITS in bits 7:0. A word write stores bits 15:8 at a and bits 7:0 at a+1, with the same wrap.
- R4: With lane mode 2'b00, a byte read returns the byte at a copied into both halves, {b,b}. A byte write stores `bus_wdata[7:0]` at a.
- R5: With lane mode 2'b01 (upper lane only), the storage index is a>>1. A word read returns {byte, 8'hFF}. A word write stores `bus_wdata[15:8]`.
- R6: With lane mode 2'b10 (lower lane only), the storage index is a>>1. A word read returns {8'hFF, byte}. A word write stores `bus_wdata[7:0]`.
- R7: In a single-lane mode, a byte read on the unconnected lane returns 16'hFFFF. That lane is an odd address in mode 2'b01 and an even address in mode 2'b10. A byte read on the connected lane returns {b,b}.
- R8: In a single-lane mode, a byte write on the unconnected lane changes no storage. A byte write on the connected lane stores `bus_wdata[7:0]` at a>>1.
- R9: A write changes storage only while `wr_ctrl` equals 2'b01. The values 2'b00, 2'b10 and 2'b11 block all writes.
- R10: `bus_rdata` takes the read result at the clock edge that samples `bus_rd` high. It keeps its value in every cycle without a read.
- R11: When `bus_rd` and `bus_wr` are high in the same cycle, no storage changes and `bus_rdata` keeps its value.
- R12: Lane mode 2'b11 behaves exactly like mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read register |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| lane_mode | input | 2 | 00/11 both lanes, 01 upper lane only, 10 lower lane only |
| wr_ctrl | input | 2 | Write control; 01 unlocks writes |
| bus_rdata | output | 16 | Registered read data |

## Verification
The bench targets index mapping across modes. It writes a byte in one wiring mode and reads it back in another. A design that forgot to halve the address in a single-lane mode would return the wrong byte.

It also covers:
- Word accesses at the top of the window. A design without the wrap to index 0 would corrupt a byte outside the window or read the wrong one.
- Byte writes and reads on the dead lane. A design that did not drop the write would overwrite the neighbouring byte; one without the 0xFF fill would return stored data.
- Each locked write-control value, and a simultaneous read and write. A wrong design would corrupt storage or disturb the held read data.
- The cycle in which read data changes, since an unregistered output would change early.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    LANE_BOTH     = 2'b00,
    LANE_UPPER    = 2'b01,
    LANE_LOWER    = 2'b10,
    LANE_BOTH_ALT = 2'b11
  } lane_mode_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [1:0] WR_UNLOCK = 2'b01;

  // True when only one data lane carries storage
  function automatic logic is_single_lane(lane_mode_e m);
    return (m == LANE_UPPER) || (m == LANE_LOWER);
  endfunction

  // True when a byte at an address with low bit a0 has storage behind it
  function automatic logic lane_connected(lane_mode_e m, logic a0);
    case (m)
      LANE_UPPER: return !a0;
      LANE_LOWER: return a0;
      default:    return 1'b1;
    endcase
  endfunction

  // Assemble the 16-bit read value from the one or two fetched bytes
  function automatic logic [15:0] merge_read(lane_mode_e m, logic word,
                                              logic hit, logic [7:0] b0,
                                              logic [7:0] b1);
    if (!word) begin
      return hit ? {b0, b0} : {FILL_BYTE, FILL_BYTE};
    end
    case (m)
      LANE_UPPER: return {b0, FILL_BYTE};
      LANE_LOWER: return {FILL_BYTE, b0};
      default:    return {b0, b1};
    endcase
  endfunction

  // Pick the byte that goes to the primary storage index on a write
  function automatic logic [7:0] primary_wbyte(lane_mode_e m, logic word,
                                               logic [15:0] d);
    if (!word) return d[7:0];
    if (m == LANE_LOWER) return d[7:0];
    return d[15:8];
  endfunction

endpackage

// File: rtl/lane_addr_map.sv
module lane_addr_map
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  lane_mode_e          mode,
  output logic [WIN_BITS-1:0] idx_pri,
  output logic [WIN_BITS-1:0] idx_sec,
  output logic                byte_hit,
  output logic                single
);

  logic [WIN_BITS-1:0] win;
  logic                unused_hi_bits;

  // Size mask: keep only the window bits of the address
  function automatic logic [WIN_BITS-1:0] mask_addr(logic [ADDR_W-1:0] a);
    return a[WIN_BITS-1:0];
  endfunction

  // Storage index of the first byte of an access
  function automatic logic [WIN_BITS-1:0] first_index(logic [WIN_BITS-1:0] w,
                                                      logic one_lane);
    return one_lane ? (w >> 1) : w;
  endfunction

  // Storage index of the second byte; wraps inside the window
  function automatic logic [WIN_BITS-1:0] next_index(logic [WIN_BITS-1:0] w,
                                                     logic one_lane);
    return one_lane ? (w >> 1) : (w + 1'b1);
  endfunction

  generate
    if (ADDR_W > WIN_BITS) begin : g_hi
      assign unused_hi_bits = ^addr[ADDR_W-1:WIN_BITS];
    end else begin : g_nohi
      assign unused_hi_bits = 1'b0;
    end
  endgenerate

  always_comb begin
    win      = mask_addr(addr);
    single   = is_single_lane(mode);
    idx_pri  = first_index(win, single);
    idx_sec  = next_index(win, single);
    byte_hit = lane_connected(mode, win[0]);
  end

  // R5 / R6: a halved index never reaches the upper half of storage
  always_comb begin
    assert_half_index_R5: assert (!single || (idx_pri[WIN_BITS-1] == 1'b0));
  end

endmodule

// File: rtl/lane_store.sv
module lane_store #(
  parameter int WIN_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_a,
  input  logic [WIN_BITS-1:0] widx_a,
  input  logic [7:0]          wbyte_a,
  input  logic                we_b,
  input  logic [WIN_BITS-1:0] widx_b,
  input  logic [7:0]          wbyte_b,
  input  logic [WIN_BITS-1:0] ridx_a,
  input  logic [WIN_BITS-1:0] ridx_b,
  output logic [7:0]          rbyte_a,
  output logic [7:0]          rbyte_b
);

  localparam int DEPTH = 1 << WIN_BITS;

  logic [7:0] mem [DEPTH];

  // Battery-backed contents: no reset
  always_ff @(posedge clk) begin
    if (we_a) mem[widx_a] <= wbyte_a;
    if (we_b) mem[widx_b] <= wbyte_b;
  end

  assign rbyte_a = mem[ridx_a];
  assign rbyte_b = mem[ridx_b];

  // R3: the two halves of a word write never land on one byte
  assert_distinct_ports_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (widx_a != widx_b));

endmodule

// File: rtl/lane_read_merge.sv
module lane_read_merge
  import sram_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  lane_mode_e mode,
  input  logic       word,
  input  logic       byte_hit,
  input  logic [7:0] byte_pri,
  input  logic [7:0] byte_sec,
  output logic [15:0] rdata
);

  logic [15:0] merged;

  assign merged = merge_read(mode, word, byte_hit, byte_pri, byte_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (load) rdata <= merged;
  end

  // R10: no read, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(rdata));

  // R5: upper-lane word reads fill the lower half
  assert_upper_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word && mode == LANE_UPPER) |=> (rdata[7:0] == 8'hFF));

  // R6: lower-lane word reads fill the upper half
  assert_lower_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word && mode == LANE_LOWER) |=> (rdata[15:8] == 8'hFF));

  // R7: byte reads on a dead lane return all ones
  assert_dead_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !word && !byte_hit) |=> (rdata == 16'hFFFF));

endmodule

// File: rtl/sram_lane_adapter.sv
module sram_lane_adapter
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_word,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        lane_mode,
  input  logic [1:0]        wr_ctrl,
  output logic [15:0]       bus_rdata
);

  lane_mode_e          mode;
  logic [WIN_BITS-1:0] idx_pri, idx_sec;
  logic                byte_hit, single;
  logic [7:0]          byte_pri, byte_sec;

  // Named internal events
  logic rd_fire, wr_fire, wr_unlocked, wr_lane_ok;
  logic store_we_a, store_we_b;
  logic [7:0] wbyte_a;

  assign mode = lane_mode_e'(lane_mode);

  lane_addr_map #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_map (
    .addr     (bus_addr),
    .mode     (mode),
    .idx_pri  (idx_pri),
    .idx_sec  (idx_sec),
    .byte_hit (byte_hit),
    .single   (single)
  );

  assign rd_fire     = bus_rd && !bus_wr;
  assign wr_fire     = bus_wr && !bus_rd;
  assign wr_unlocked = (wr_ctrl == WR_UNLOCK);
  assign wr_lane_ok  = bus_word || byte_hit;
  assign store_we_a  = wr_fire && wr_unlocked && wr_lane_ok;
  assign store_we_b  = wr_fire && wr_unlocked && bus_word && !single;
  assign wbyte_a     = primary_wbyte(mode, bus_word, bus_wdata);

  lane_store #(.WIN_BITS(WIN_BITS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_a    (store_we_a),
    .widx_a  (idx_pri),
    .wbyte_a (wbyte_a),
    .we_b    (store_we_b),
    .widx_b  (idx_sec),
    .wbyte_b (bus_wdata[7:0]),
    .ridx_a  (idx_pri),
    .ridx_b  (idx_sec),
    .rbyte_a (byte_pri),
    .rbyte_b (byte_sec)
  );

  lane_read_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_fire),
    .mode     (mode),
    .word     (bus_word),
    .byte_hit (byte_hit),
    .byte_pri (byte_pri),
    .byte_sec (byte_sec),
    .rdata    (bus_rdata)
  );

  // R9: storage is written only while unlocked
  assert_write_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_we_a || store_we_b) |-> (wr_ctrl == 2'b01));

  // R11: a colliding strobe pair writes nothing
  assert_collision_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |-> !(store_we_a || store_we_b));

  // R11: a colliding strobe pair leaves read data alone
  assert_collision_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> $stable(bus_rdata));

  // R8: dead-lane byte writes reach no storage port
  assert_dead_lane_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_word && (lane_mode == 2'b01) && bus_addr[0]) |-> !(store_we_a || store_we_b));

endmodule

// File: tb/test_sram_lane_adapter.sv
module test_sram_lane_adapter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  lane_mode = 2'b00;
  logic [1:0]  wr_ctrl = 2'b01;
  logic [15:0] bus_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_lane_adapter #(.ADDR_W(24), .WIN_BITS(8)) i_sram_lane_adapter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .lane_mode(lane_mode), .wr_ctrl(wr_ctrl), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [23:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_word = w; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [23:0] a, input logic w, output logic [15:0] r);
    @(negedge clk);
    bus_addr = a; bus_word = w; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    r = bus_rdata;
  endtask

  task automatic t_reset();
    check("R1 reset rdata", bus_rdata, 16'h0000);
  endtask

  task automatic t_both_lanes();
    logic [15:0] r;
    lane_mode = 2'b00; wr_ctrl = 2'b01;
    bus_write(24'h000010, 1'b1, 16'h1234);
    bus_read(24'h000010, 1'b1, r);  check("R3 word read", r, 16'h1234);
    bus_read(24'h000011, 1'b0, r);  check("R3 lower byte at a+1", r, 16'h3434);
    bus_write(24'h000012, 1'b0, 16'hAA56);
    bus_write(24'h000013, 1'b0, 16'hBB78);
    bus_read(24'h000012, 1'b1, r);  check("R4 byte writes", r, 16'h5678);
    bus_write(24'h0000FF, 1'b1, 16'h9ABC);
    bus_read(24'h000000, 1'b0, r);  check("R3 word write wrap", r, 16'hBCBC);
    bus_read(24'h0000FF, 1'b1, r);  check("R3 word read wrap", r, 16'h9ABC);
  endtask

  task automatic t_mask_alias();
    logic [15:0] r;
    lane_mode = 2'b00;
    bus_read(24'h010010, 1'b1, r);  check("R2 alias read", r, 16'h1234);
    bus_write(24'hFF0020, 1'b0, 16'h0011);
    bus_read(24'h000020, 1'b0, r);  check("R2 alias write", r, 16'h1111);
  endtask

  task automatic t_upper_lane();
    logic [15:0] r;
    lane_mode = 2'b01;
    bus_write(24'h000040, 1'b1, 16'hC3D4);
    bus_read(24'h000040, 1'b1, r);  check("R5 upper word read", r, 16'hC3FF);
    bus_read(24'h000040, 1'b0, r);  check("R7 upper live byte", r, 16'hC3C3);
    lane_mode = 2'b00;
    bus_read(24'h000020, 1'b0, r);  check("R5 halved index", r, 16'hC3C3);
  endtask

  task automatic t_lower_lane();
    logic [15:0] r;
    lane_mode = 2'b10;
    bus_write(24'h000060, 1'b1, 16'hE5F6);
    bus_read(24'h000061, 1'b1, r);  check("R6 lower word read", r, 16'hFFF6);
    lane_mode = 2'b00;
    bus_read(24'h000030, 1'b0, r);  check("R6 halved index", r, 16'hF6F6);
  endtask

  task automatic t_dead_lane();
    logic [15:0] r;
    lane_mode = 2'b01;
    bus_read(24'h000041, 1'b0, r);  check("R7 upper mode odd byte", r, 16'hFFFF);
    bus_write(24'h000041, 1'b0, 16'h0000);
    bus_read(24'h000040, 1'b1, r);  check("R8 upper mode odd write dropped", r, 16'hC3FF);
    bus_write(24'h000040, 1'b0, 16'h0077);
    bus_read(24'h000040, 1'b1, r);  check("R8 upper mode live byte write", r, 16'h77FF);
    lane_mode = 2'b10;
    bus_read(24'h000060, 1'b0, r);  check("R7 lower mode even byte", r, 16'hFFFF);
    bus_read(24'h000061, 1'b0, r);  check("R7 lower mode live byte", r, 16'hF6F6);
    bus_write(24'h000060, 1'b0, 16'h0000);
    bus_read(24'h000061, 1'b0, r);  check("R8 lower mode even write dropped", r, 16'hF6F6);
  endtask

  task automatic t_locked();
    logic [15:0] r;
    lane_mode = 2'b00;
    for (int c = 0; c < 4; c++) begin
      if (c != 1) begin
        wr_ctrl = 2'(c);
        bus_write(24'h000010, 1'b1, 16'hDEAD);
      end
    end
    wr_ctrl = 2'b01;
    bus_read(24'h000010, 1'b1, r);  check("R9 locked writes", r, 16'h1234);
  endtask

  task automatic t_collision();
    logic [15:0] r;
    lane_mode = 2'b00;
    bus_read(24'h000012, 1'b1, r);
    @(negedge clk);
    bus_addr = 24'h000010; bus_word = 1'b1; bus_wdata = 16'hBEEF;
    bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R11 collision holds rdata", bus_rdata, 16'h5678);
    bus_read(24'h000010, 1'b1, r);  check("R11 collision no write", r, 16'h1234);
  endtask

  task automatic t_latency();
    lane_mode = 2'b00;
    @(negedge clk);
    bus_addr = 24'h000000; bus_word = 1'b0; bus_rd = 1'b1;
    #1 check("R10 before edge", bus_rdata, 16'h1234);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 after edge", bus_rdata, 16'hBCBC);
    bus_addr = 24'h000010;
    repeat (3) @(negedge clk);
    check("R10 hold while idle", bus_rdata, 16'hBCBC);
  endtask

  task automatic t_alt_mode();
    logic [15:0] r;
    lane_mode = 2'b11;
    bus_read(24'h000010, 1'b1, r);  check("R12 mode 11 word", r, 16'h1234);
    bus_read(24'h000013, 1'b0, r);  check("R12 mode 11 odd byte", r, 16'h7878);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_both_lanes();
    t_mask_alias();
    t_upper_lane();
    t_lower_lane();
    t_dead_lane();
    t_locked();
    t_collision();
    t_latency();
    t_alt_mode();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule